// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

A slave that was cut off mid-byte can keep holding the data line low, and then the two-wire bus stays stuck. This block frees it. It toggles the clock line while the data line stays released, so that the stuck device can shift out the rest of its byte and let go. It then builds a stop condition out of override phases and finally releases both lines.

Both lines are open-drain. The block never drives a line high. It only asserts a drive-low request for each line, and an outside pad turns that request into an output enable. A one-cycle start pulse launches the sequence. A busy flag stays high until the last phase has ended. Every phase lasts a programmable number of reference-clock cycles. The default is 500, which is 5 µs on a 100 MHz clock.

A pin view word reports the two override bits and the two synchronized line levels. The fields sit at fixed bit positions so that existing decoders can read them. This block does not check whether the bus actually recovered, and it does not perform normal byte transfers.

Top module: `twoWireRecovery`

## Requirements
- R1: After reset, `busy` is 0, both drive-low outputs are 0, and pin view bits 9:8 are 0.
- R2: A start pulse sampled while idle sets `busy` at that clock edge, and the first phase begins with both lines released.
- R3: The sequence begins with nine clock pulses, which form 18 phases. An even phase (0, 2, … 16) releases both lines. An odd phase (1, 3, … 17) drives only SCL low. SDA stays released throughout these phases.
- R4: Phase 18 drives both SCL and SDA low. Phase 19 drives only SDA low. Together they form the stop condition.
- R5: Phase 20 releases both lines. `busy` clears at the edge that ends it, so `busy` stays high for exactly 21 × `PHASE_CYCLES` cycles.
- R6: Every phase lasts exactly `PHASE_CYCLES` reference-clock cycles, and the drive outputs change only at phase boundaries.
- R7: A start pulse while `busy` is high is ignored. The running sequence keeps its order and length.
- R8: The pin view places the SDA override at bit 8 and the SCL override at bit 9. Bits 7:0 always read 0.
- R9: Pin view bit 10 shows `sdaIn` and bit 11 shows `sclIn`, each through a two-flop synchronizer. The delay is two edges, and both bits reset to 1.
- R10: A drive-low output is 1 only while its override bit in the pin view is 1. A 1 pulls the line low. A 0 releases the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Launches a recovery sequence when sampled high while idle |
| sclIn | input | 1 | Raw level of the SCL line |
| sdaIn | input | 1 | Raw level of the SDA line |
| busy | output | 1 | High while a sequence runs |
| sclDriveLow | output | 1 | Request to pull SCL low |
| sdaDriveLow | output | 1 | Request to pull SDA low |
| pinView | output | 12 | Bit 8 is the SDA override, bit 9 the SCL override, bit 10 the synced SDA level, bit 11 the synced SCL level |

## Verification
The bench builds the block with `PHASE_CYCLES` = 3 and the default nine pulses. With these values a whole 63-cycle sequence can be compared cycle by cycle, including the exact edges where each phase ends. The odd phase length means that an error in the counter bound shifts every later boundary where the bench sees it. The short run also leaves room for a second start during busy and for a back-to-back restart. The synchronizer delay is checked separately by toggling the raw lines while the block is idle.

// File: rtl/recov_pkg.sv
package recov_pkg;
  // fixed field positions in the pin view word
  localparam int SDA_OVR_BIT = 8;
  localparam int SCL_OVR_BIT = 9;
  localparam int SDA_LVL_BIT = 10;
  localparam int SCL_LVL_BIT = 11;
  localparam int VIEW_W      = 12;

  typedef struct packed {
    logic load;    // take new override values this edge
    logic sclOvr;
    logic sdaOvr;
  } recovCmd_t;
endpackage

// File: rtl/recov_ctrl.sv
module recov_ctrl
  import recov_pkg::*;
#(
  parameter int PHASE_CYCLES = 500,
  parameter int PULSE_COUNT  = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  output logic      busy,
  output recovCmd_t cmd
);
  localparam int PULSE_PHASES = 2 * PULSE_COUNT;
  localparam int TOTAL_PHASES = PULSE_PHASES + 3;
  localparam int IDX_W = $clog2(TOTAL_PHASES);
  localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_PHASES - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PHASE_CYCLES - 1);

  logic             busyQ;
  logic [IDX_W-1:0] idxQ;
  logic [CNT_W-1:0] cntQ;
  logic             accept, endPhase, lastPhase;

  // {scl, sda} override pair for a given phase index
  function automatic logic [1:0] phaseDrive(input logic [IDX_W-1:0] idx);
    if (idx < IDX_W'(PULSE_PHASES))          return {idx[0], 1'b0};
    else if (idx == IDX_W'(PULSE_PHASES))    return 2'b11;
    else if (idx == IDX_W'(PULSE_PHASES + 1)) return 2'b01;
    else                                      return 2'b00;
  endfunction

  assign accept    = !busyQ && startPulse;
  assign endPhase  = busyQ && (cntQ == LAST_CNT);
  assign lastPhase = (idxQ == LAST_IDX);
  assign busy      = busyQ;

  always_comb begin
    cmd = '0;
    if (accept) begin
      cmd.load = 1'b1;
      {cmd.sclOvr, cmd.sdaOvr} = phaseDrive('0);
    end else if (endPhase) begin
      cmd.load = 1'b1;
      if (!lastPhase) {cmd.sclOvr, cmd.sdaOvr} = phaseDrive(idxQ + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
      cntQ  <= '0;
    end else if (accept) begin
      busyQ <= 1'b1;
      idxQ  <= '0;
      cntQ  <= '0;
    end else if (busyQ) begin
      if (cntQ == LAST_CNT) begin
        cntQ <= '0;
        if (lastPhase) begin
          busyQ <= 1'b0;
          idxQ  <= '0;
        end else begin
          idxQ <= idxQ + 1'b1;
        end
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end
endmodule

// File: rtl/recov_dpath.sv
module recov_dpath
  import recov_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  recovCmd_t         cmd,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic [VIEW_W-1:0] pinView
);
  logic       sclOvrQ, sdaOvrQ;
  logic [1:0] rawLine;
  logic [1:0] syncOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOvrQ <= 1'b0;
      sdaOvrQ <= 1'b0;
    end else if (cmd.load) begin
      sclOvrQ <= cmd.sclOvr;
      sdaOvrQ <= cmd.sdaOvr;
    end
  end

  assign rawLine = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawLine[g]};
    end
    assign syncOut[g] = chain[SYNC_STAGES-1];
  end

  assign sclDriveLow = sclOvrQ;
  assign sdaDriveLow = sdaOvrQ;

  always_comb begin
    pinView              = '0;
    pinView[SDA_OVR_BIT] = sdaOvrQ;
    pinView[SCL_OVR_BIT] = sclOvrQ;
    pinView[SDA_LVL_BIT] = syncOut[0];
    pinView[SCL_LVL_BIT] = syncOut[1];
  end
endmodule

// File: rtl/twoWireRecovery.sv
module twoWireRecovery
  import recov_pkg::*;
#(
  parameter int PHASE_CYCLES = 500,
  parameter int PULSE_COUNT  = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        busy,
  output logic        sclDriveLow,
  output logic        sdaDriveLow,
  output logic [11:0] pinView
);
  recovCmd_t cmd;

  recov_ctrl #(.PHASE_CYCLES(PHASE_CYCLES), .PULSE_COUNT(PULSE_COUNT)) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .busy(busy), .cmd(cmd)
  );

  recov_dpath #(.SYNC_STAGES(2)) dpath_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .pinView(pinView)
  );
endmodule

// File: rtl/twoWireRecovery_chk.sv
module twoWireRecovery_chk #(
  parameter int PHASE_CYCLES = 500,
  parameter int PULSE_COUNT  = 9
) (
  input logic        clk,
  input logic        rstN,
  input logic        startPulse,
  input logic        sclIn,
  input logic        sdaIn,
  input logic        busy,
  input logic        sclDriveLow,
  input logic        sdaDriveLow,
  input logic [11:0] pinView
);
  localparam int BUSY_LEN = (2 * PULSE_COUNT + 3) * PHASE_CYCLES;

  int busyLen;
  int age;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyLen <= 0;
      age     <= 0;
    end else begin
      busyLen <= busy ? busyLen + 1 : 0;
      if (age < 3) age <= age + 1;
    end
  end

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse) |=> busy);

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == BUSY_LEN));

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDriveLow && !sdaDriveLow));

  // R4
  stop_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> (sclDriveLow && $past(sclDriveLow)));

  // R9
  sda_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2) |-> (pinView[10] == $past(sdaIn, 2)));

  // R9
  scl_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2) |-> (pinView[11] == $past(sclIn, 2)));
endmodule

bind twoWireRecovery twoWireRecovery_chk #(
  .PHASE_CYCLES(PHASE_CYCLES), .PULSE_COUNT(PULSE_COUNT)
) chk_i (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .sclIn(sclIn), .sdaIn(sdaIn),
  .busy(busy), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .pinView(pinView)
);

// File: tb/twoWireRecovery_tb_top.sv
`timescale 1ns/1ps
module twoWireRecovery_tb_top;
  localparam int P      = 3;
  localparam int PHASES = 21;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        sclIn = 1'b1;
  logic        sdaIn = 1'b1;
  logic        busy, sclDriveLow, sdaDriveLow;
  logic [11:0] pinView;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected {busy, scl, sda} per cycle, with requirement tag
  logic [2:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  twoWireRecovery #(.PHASE_CYCLES(P), .PULSE_COUNT(9)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .sclIn(sclIn), .sdaIn(sdaIn),
    .busy(busy), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .pinView(pinView)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: launch one sequence and queue the expected outputs of every cycle
  task automatic launch(input string endTag);
    @(negedge clk);
    startPulse = 1'b1;
    for (int k = 0; k < PHASES; k++) begin
      logic scl, sda;
      string t;
      if (k < 18) begin scl = k[0]; sda = 1'b0; t = "R3"; end     // R3 pulses
      else if (k == 18) begin scl = 1'b1; sda = 1'b1; t = "R4"; end
      else if (k == 19) begin scl = 1'b0; sda = 1'b1; t = "R4"; end
      else begin scl = 1'b0; sda = 1'b0; t = "R5"; end
      for (int c = 0; c < P; c++) begin   // R6 phase length
        expQ.push_back({1'b1, scl, sda});
        tagQ.push_back(t);
      end
    end
    expQ.push_back(3'b000);
    tagQ.push_back(endTag);
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  // monitor: compare one item per cycle, 2 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        logic [2:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {busy, sclDriveLow, sdaDriveLow}, e);
        check({t, "/R8"}, {pinView[9], pinView[8]}, e[1:0]);   // R10 link
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {busy, sclDriveLow, sdaDriveLow}, 3'b000);
    check("R1", pinView[9:8], 2'b00);
    check("R8", pinView[7:0], 8'h00);
    check("R9", pinView[11:10], 2'b11);

    // R9 synchronizer latency on SDA then SCL
    sdaIn = 1'b0;
    @(posedge clk); #2; check("R9", pinView[10], 1'b1);
    @(posedge clk); #2; check("R9", pinView[10], 1'b0);
    sclIn = 1'b0;
    @(posedge clk); #2; check("R9", pinView[11], 1'b1);
    @(posedge clk); #2; check("R9", pinView[11], 1'b0);
    @(negedge clk);
    sdaIn = 1'b0; sclIn = 1'b1;

    // R2 R3 R4 R5 R6: plain sequence
    launch("R5");
    drain();

    // R7: second start mid-run must not change anything
    launch("R7");
    repeat (10) @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    repeat (20) @(negedge clk);
    startPulse = 1'b1;   // held several cycles while busy
    repeat (3) @(negedge clk);
    startPulse = 1'b0;
    drain();
    repeat (2) @(negedge clk);
    check("R7", {busy, sclDriveLow, sdaDriveLow}, 3'b000);

    // R2: restart right after completion
    launch("R5");
    drain();
    check("R8", pinView[7:0], 8'h00);
    check("R9", pinView[11:10], 2'b10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule